// File: doc/BRIEF.md
# Double-Buffered Reference Divider and Transmit Gain Register Bank

This block is a small register bank sitting behind a byte-wide host port with an address, write data, a write strobe, a read strobe and registered read data. It keeps a 13-bit reference-divider value that is split over a low byte and a high byte. It also keeps two enable bits that share the high byte, and a transmit I/Q input gain register whose two top bits pick one of three gain settings.

The divider value is double-buffered. Each byte first lands in a staging register. The active divider output moves only after both bytes have been written since the last update. The two writes may come in either order, and a single-cycle update pulse marks the moment the new value takes effect. The enable bits in the high byte skip the staging step and act at once.

Reading the high byte returns the live lock-status input in place of the bit the host is told to write as zero. A second, read-only address returns the same value as the gain register. A synchronous general-reset command returns every register to its cleared state.

Top module: `divreg_bank`

## Requirements
- R1: The divider value is formed from two bytes. Bits 12..8 come from bits 4..0 of a write to address 0x21, and bits 7..0 come from a write to address 0x20. `ref_div` keeps its value until both bytes have been written since the last update, and it changes on the clock edge of the second of those writes, whichever byte that is.
- R2: An update raises `div_commit` for exactly one cycle, the cycle after the completing write. It also clears both written flags, so the next update needs two fresh writes.
- R3: Writing the same divider byte again before the other byte arrives replaces its staged value and causes no update.
- R4: A write to address 0x21 sets `pll_en` from data bit 7 and `cp_en` from data bit 5 on the edge of that write, with no wait for the low byte.
- R5: A read of 0x21 returns {pll_en, lock_stat, cp_en, staged bits 12..8}, with `lock_stat` sampled at the read strobe. A read of 0x20 returns the staged low byte.
- R6: A write to 0x16 stores data bits 7:6, and bits 5:0 always read back as 0. A read of 0xE6 returns the same byte as a read of 0x16, and writes to 0xE6 change nothing.
- R7: `gain_sel` is one-hot and decodes the stored gain code: code 00 gives 3'b001 (0 dB), code 01 gives 3'b010 (-6 dB), and code 10 gives 3'b100 (+6 dB).
- R8: Writing gain code 11 raises `gain_err` for one cycle and leaves `gain_sel` at its previous legal value. The raw code 11 is still stored and read back.
- R9: Asserting `gen_reset` for one cycle clears the gain register, both staged bytes, both written flags, `ref_div`, `pll_en` and `cp_en`, and sets `gain_sel` to 3'b001. Asynchronous `rst_n` gives the same state.
- R10: `bus_rdata` is registered. It shows the addressed byte in the cycle after a read strobe and 0x00 otherwise. Reads of any unmapped address return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_reset | input | 1 | Synchronous general-reset command |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| lock_stat | input | 1 | Live lock-status input |
| pll_en | output | 1 | Loop enable, acts at once |
| cp_en | output | 1 | Charge-pump enable, 0 means high impedance |
| ref_div | output | 13 | Active reference-divider value |
| div_commit | output | 1 | One-cycle pulse when `ref_div` updates |
| gain_sel | output | 3 | One-hot decoded gain select |
| gain_err | output | 1 | One-cycle pulse on a reserved gain code |

## Verification
The bench builds the block with its default parameters: a 13-bit divider, 8-bit addresses, and the gain, mirror, low-divider and high-divider addresses at 0x16, 0xE6, 0x20 and 0x21. With these defaults the full five-bit upper field is exercised next to the enable bits and the lock bit, so an all-ones upper field (0x1FFF) can be told apart from a value that has lost a bit. Because the real mirror and unmapped addresses are used, stray decodes show up as visible read-back errors. Updates in both write orders, repeated writes of one byte and a general reset in the middle of a sequence are each checked against expected values.

// File: rtl/divreg_pkg.sv
package divreg_pkg;

    // stored two-bit gain codes
    localparam logic [1:0] GCODE_ZERO  = 2'b00;
    localparam logic [1:0] GCODE_MINUS = 2'b01;
    localparam logic [1:0] GCODE_PLUS  = 2'b10;
    localparam logic [1:0] GCODE_RSVD  = 2'b11;

    // one-hot select values
    localparam logic [2:0] GSEL_ZERO  = 3'b001;
    localparam logic [2:0] GSEL_MINUS = 3'b010;
    localparam logic [2:0] GSEL_PLUS  = 3'b100;

    function automatic logic [2:0] gain_decode(input logic [1:0] code);
        logic [2:0] sel;
        case (code)
            GCODE_MINUS: sel = GSEL_MINUS;
            GCODE_PLUS:  sel = GSEL_PLUS;
            default:     sel = GSEL_ZERO;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/div_stage.sv
module div_stage #(
    parameter int DIV_W = 13,
    parameter int HI_W  = DIV_W - 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [7:0]       wdata,
    output logic [7:0]       staged_lo,
    output logic [HI_W-1:0]  staged_hi,
    output logic [DIV_W-1:0] ref_div,
    output logic             commit,
    output logic             pll_en,
    output logic             cp_en
);

    typedef struct packed {
        logic [7:0]       lo;
        logic [HI_W-1:0]  hi;
        logic             lo_seen;
        logic             hi_seen;
        logic [DIV_W-1:0] act;
        logic             upd;
        logic             pll;
        logic             cp;
    } stage_t;

    stage_t st_d, st_q;

    // bit 6 of the high byte is the lock position; nothing is stored there
    logic unused_lockbit;
    assign unused_lockbit = wdata[6];

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (clr) begin
            st_d = '0;
        end else begin
            if (wr_lo) begin
                st_d.lo      = wdata;
                st_d.lo_seen = 1'b1;
            end
            if (wr_hi) begin
                st_d.hi      = wdata[HI_W-1:0];
                st_d.hi_seen = 1'b1;
                st_d.pll     = wdata[7];
                st_d.cp      = wdata[5];
            end
            if (st_d.lo_seen && st_d.hi_seen) begin
                st_d.act     = {st_d.hi, st_d.lo};
                st_d.upd     = 1'b1;
                st_d.lo_seen = 1'b0;
                st_d.hi_seen = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign staged_lo = st_q.lo;
    assign staged_hi = st_q.hi;
    assign ref_div   = st_q.act;
    assign commit    = st_q.upd;
    assign pll_en    = st_q.pll;
    assign cp_en     = st_q.cp;

endmodule

// File: rtl/gain_ctrl.sv
module gain_ctrl
    import divreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       wr,
    input  logic [1:0] wcode,
    output logic [1:0] code,
    output logic [2:0] sel,
    output logic       err
);

    typedef struct packed {
        logic [1:0] code;
        logic [2:0] sel;
        logic       err;
    } gain_t;

    localparam gain_t GAIN_RST = '{code: GCODE_ZERO, sel: GSEL_ZERO, err: 1'b0};

    gain_t g_d, g_q;

    always_comb begin
        g_d     = g_q;
        g_d.err = 1'b0;
        if (clr) begin
            g_d = GAIN_RST;
        end else if (wr) begin
            g_d.code = wcode;
            if (wcode == GCODE_RSVD) g_d.err = 1'b1;
            else                     g_d.sel = gain_decode(wcode);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= GAIN_RST;
        else        g_q <= g_d;
    end

    assign code = g_q.code;
    assign sel  = g_q.sel;
    assign err  = g_q.err;

endmodule

// File: rtl/rd_mux.sv
module rd_mux #(
    parameter int              ADDR_W      = 8,
    parameter int              HI_W        = 5,
    parameter logic [ADDR_W-1:0] GAIN_ADDR = 8'h16,
    parameter logic [ADDR_W-1:0] MIRR_ADDR = 8'hE6,
    parameter logic [ADDR_W-1:0] LO_ADDR   = 8'h20,
    parameter logic [ADDR_W-1:0] HI_ADDR   = 8'h21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        gain_code,
    input  logic [7:0]        staged_lo,
    input  logic [HI_W-1:0]   staged_hi,
    input  logic              pll_en,
    input  logic              cp_en,
    input  logic              lock_stat,
    output logic [7:0]        rdata
);

    typedef struct packed {
        logic [7:0] data;
    } rd_t;

    rd_t r_d, r_q;
    logic [4:0] hi_ext;
    logic [7:0] sel_byte;

    always_comb begin
        hi_ext             = '0;
        hi_ext[HI_W-1:0]   = staged_hi;
        if (addr == GAIN_ADDR || addr == MIRR_ADDR)
            sel_byte = {gain_code, 6'b0};
        else if (addr == LO_ADDR)
            sel_byte = staged_lo;
        else if (addr == HI_ADDR)
            sel_byte = {pll_en, lock_stat, cp_en, hi_ext};
        else
            sel_byte = 8'h00;
        r_d.data = rd ? sel_byte : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata = r_q.data;

endmodule

// File: rtl/divreg_bank.sv
module divreg_bank #(
    parameter int                DIV_W     = 13,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] GAIN_ADDR = 8'h16,
    parameter logic [ADDR_W-1:0] MIRR_ADDR = 8'hE6,
    parameter logic [ADDR_W-1:0] LO_ADDR   = 8'h20,
    parameter logic [ADDR_W-1:0] HI_ADDR   = 8'h21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_reset,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic              lock_stat,
    output logic              pll_en,
    output logic              cp_en,
    output logic [DIV_W-1:0]  ref_div,
    output logic              div_commit,
    output logic [2:0]        gain_sel,
    output logic              gain_err
);

    localparam int HI_W = DIV_W - 8;

    logic            wr_gain, wr_lo, wr_hi;
    logic [7:0]      staged_lo;
    logic [HI_W-1:0] staged_hi;
    logic [1:0]      gain_code;

    // the mirror address is read-only, so it never decodes a write
    assign wr_gain = bus_wr && (bus_addr == GAIN_ADDR);
    assign wr_lo   = bus_wr && (bus_addr == LO_ADDR);
    assign wr_hi   = bus_wr && (bus_addr == HI_ADDR);

    div_stage #(.DIV_W(DIV_W), .HI_W(HI_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (gen_reset),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .wdata     (bus_wdata),
        .staged_lo (staged_lo),
        .staged_hi (staged_hi),
        .ref_div   (ref_div),
        .commit    (div_commit),
        .pll_en    (pll_en),
        .cp_en     (cp_en)
    );

    gain_ctrl u_gain (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (gen_reset),
        .wr    (wr_gain),
        .wcode (bus_wdata[7:6]),
        .code  (gain_code),
        .sel   (gain_sel),
        .err   (gain_err)
    );

    rd_mux #(
        .ADDR_W    (ADDR_W),
        .HI_W      (HI_W),
        .GAIN_ADDR (GAIN_ADDR),
        .MIRR_ADDR (MIRR_ADDR),
        .LO_ADDR   (LO_ADDR),
        .HI_ADDR   (HI_ADDR)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (bus_rd),
        .addr      (bus_addr),
        .gain_code (gain_code),
        .staged_lo (staged_lo),
        .staged_hi (staged_hi),
        .pll_en    (pll_en),
        .cp_en     (cp_en),
        .lock_stat (lock_stat),
        .rdata     (bus_rdata)
    );

endmodule

// File: rtl/divreg_bank_chk.sv
module divreg_bank_chk #(
    parameter int                DIV_W     = 13,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] GAIN_ADDR = 8'h16,
    parameter logic [ADDR_W-1:0] MIRR_ADDR = 8'hE6,
    parameter logic [ADDR_W-1:0] LO_ADDR   = 8'h20,
    parameter logic [ADDR_W-1:0] HI_ADDR   = 8'h21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gen_reset,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic [7:0]        bus_rdata,
    input logic              pll_en,
    input logic              cp_en,
    input logic [DIV_W-1:0]  ref_div,
    input logic              div_commit,
    input logic [2:0]        gain_sel,
    input logic              gain_err
);

    logic unmapped;
    assign unmapped = !(bus_addr == GAIN_ADDR || bus_addr == MIRR_ADDR ||
                        bus_addr == LO_ADDR   || bus_addr == HI_ADDR);

    AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_div) |-> (div_commit || $past(gen_reset)));                  // R1

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        div_commit |=> !div_commit);                                              // R2

    AST_GAIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gain_sel) == 1);                                               // R7

    AST_ERR_HOLDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        gain_err |-> $stable(gain_sel));                                          // R8

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        gain_err |=> !gain_err);                                                  // R8

    AST_GEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        gen_reset |=> (ref_div == '0 && !pll_en && !cp_en &&
                       gain_sel == 3'b001 && !div_commit && !gain_err));         // R9

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && unmapped) |=> bus_rdata == 8'h00);                             // R10

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == 8'h00);                                          // R10

endmodule

bind divreg_bank divreg_bank_chk #(
    .DIV_W     (DIV_W),
    .ADDR_W    (ADDR_W),
    .GAIN_ADDR (GAIN_ADDR),
    .MIRR_ADDR (MIRR_ADDR),
    .LO_ADDR   (LO_ADDR),
    .HI_ADDR   (HI_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gen_reset  (gen_reset),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .pll_en     (pll_en),
    .cp_en      (cp_en),
    .ref_div    (ref_div),
    .div_commit (div_commit),
    .gain_sel   (gain_sel),
    .gain_err   (gain_err)
);

// File: tb/tb_divreg_bank.sv
module tb_divreg_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_reset = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        lock_stat = 1'b0;
    logic        pll_en, cp_en, div_commit, gain_err;
    logic [12:0] ref_div;
    logic [2:0]  gain_sel;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;  // 50 MHz

    divreg_bank dut (
        .clk(clk), .rst_n(rst_n), .gen_reset(gen_reset),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .lock_stat(lock_stat),
        .pll_en(pll_en), .cp_en(cp_en), .ref_div(ref_div),
        .div_commit(div_commit), .gain_sel(gain_sel), .gain_err(gain_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // driver: pushes the expected byte, the monitor compares it
    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_gen_reset();
        @(negedge clk);
        gen_reset = 1'b1;
        @(posedge clk);
        @(negedge clk);
        gen_reset = 1'b0;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    chk("R10 unexpected read", 32'd1, 32'd0);
                end else begin
                    chk(tag_q.pop_front(), {24'd0, bus_rdata}, {24'd0, exp_q.pop_front()});
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk("watchdog expired", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset ref_div", ref_div, 0);
        chk("R9 reset pll_en", pll_en, 0);
        chk("R9 reset cp_en", cp_en, 0);
        chk("R9 reset gain_sel", gain_sel, 3'b001);
        chk("R2 reset div_commit", div_commit, 0);
        chk("R8 reset gain_err", gain_err, 0);
        chk("R10 reset rdata", bus_rdata, 0);

        // R1: low then high
        wr(8'h20, 8'h34);
        chk("R1 low only no update", ref_div, 0);
        chk("R2 low only no pulse", div_commit, 0);
        wr(8'hA5, 8'h00); // unmapped write, no effect
        wr(8'h21, 8'hA5);
        chk("R2 pulse after pair", div_commit, 1);
        chk("R1 value low-high", ref_div, 13'h0534);
        chk("R4 pll_en set", pll_en, 1);
        chk("R4 cp_en set", cp_en, 1);
        @(negedge clk);
        chk("R2 pulse one cycle", div_commit, 0);

        // R4 / R3: high byte twice, then low
        wr(8'h21, 8'h0A);
        chk("R4 pll_en cleared at once", pll_en, 0);
        chk("R4 cp_en cleared at once", cp_en, 0);
        chk("R2 flags cleared, no update", ref_div, 13'h0534);
        chk("R2 single high no pulse", div_commit, 0);
        wr(8'h21, 8'h1F);
        chk("R3 rewrite high no pulse", div_commit, 0);
        chk("R3 rewrite high no update", ref_div, 13'h0534);
        wr(8'h20, 8'hFF);
        chk("R1 high-low pulse", div_commit, 1);
        chk("R3 value uses last high", ref_div, 13'h1FFF);

        // R3 on the low byte
        wr(8'h20, 8'h11);
        wr(8'h20, 8'h22);
        chk("R3 rewrite low no pulse", div_commit, 0);
        chk("R3 rewrite low no update", ref_div, 13'h1FFF);
        wr(8'h21, 8'h80);
        chk("R3 value uses last low", ref_div, 13'h0022);
        chk("R4 pll only", {pll_en, cp_en}, 2'b10);

        // R5 readback
        lock_stat = 1'b0;
        rd(8'h21, 8'h80, "R5 high read lock=0");
        lock_stat = 1'b1;
        rd(8'h21, 8'hC0, "R5 high read lock=1");
        rd(8'h20, 8'h22, "R5 low read");
        lock_stat = 1'b0;

        // R6 / R7 gain register
        wr(8'h16, 8'hBF);
        chk("R7 plus select", gain_sel, 3'b100);
        rd(8'h16, 8'h80, "R6 reserved bits read 0");
        rd(8'hE6, 8'h80, "R6 mirror read");
        wr(8'hE6, 8'h40);
        chk("R6 mirror write ignored sel", gain_sel, 3'b100);
        rd(8'h16, 8'h80, "R6 mirror write ignored reg");
        wr(8'h16, 8'h40);
        chk("R7 minus select", gain_sel, 3'b010);
        rd(8'hE6, 8'h40, "R6 mirror follows");
        wr(8'h16, 8'h00);
        chk("R7 zero select", gain_sel, 3'b001);
        wr(8'h16, 8'h80);
        chk("R7 plus again", gain_sel, 3'b100);

        // R8 reserved code
        wr(8'h16, 8'hC0);
        chk("R8 err pulse", gain_err, 1);
        chk("R8 sel held", gain_sel, 3'b100);
        @(negedge clk);
        chk("R8 err one cycle", gain_err, 0);
        rd(8'h16, 8'hC0, "R8 raw code stored");

        // R10 unmapped
        rd(8'h55, 8'h00, "R10 unmapped 0x55");
        rd(8'h17, 8'h00, "R10 unmapped 0x17");
        @(negedge clk);
        chk("R10 idle rdata", bus_rdata, 0);

        // R9 general reset mid-sequence
        wr(8'h21, 8'hA3);
        wr(8'h20, 8'h12);
        wr(8'h20, 8'h56);
        do_gen_reset();
        chk("R9 ref_div cleared", ref_div, 0);
        chk("R9 enables cleared", {pll_en, cp_en}, 2'b00);
        chk("R9 gain_sel 0 dB", gain_sel, 3'b001);
        rd(8'h16, 8'h00, "R9 gain reg cleared");
        rd(8'h20, 8'h00, "R9 staged low cleared");
        rd(8'h21, 8'h00, "R9 staged high cleared");
        wr(8'h21, 8'h03);
        chk("R9 flags cleared no pulse", div_commit, 0);
        chk("R9 flags cleared no update", ref_div, 0);
        wr(8'h20, 8'h01);
        chk("R9 fresh pair commits", ref_div, 13'h0301);

        repeat (3) @(negedge clk);
        chk("R10 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule